// File: doc/BRIEF.md
# Command-62 Vendor Sequence Decoder

This block sits on the device side of a managed-flash card controller, behind the command parser. Each decoded command (a 6-bit index and a 32-bit argument) arrives on a valid/ready stream. The block looks for multi-step sequences that all use command index 62. Every sequence opens with an unlock key. The second argument then selects one of three operations:

- switch the diagnostic report mode on;
- switch the diagnostic report mode off;
- arm a boot-partition resize, which takes one more command carrying the new size.

Outputs from the block:

- `report_mode`: a level that shows whether report mode is active.
- `rd_report`: a pulse that steers a single-block read of address 0 to the report sector while report mode is on.
- `boot_upd`, `boot_size` and `erase_req`: a strobe with its value, plus an erase request. Together they tell the rest of the controller to wipe user data and refresh the boot-size and capacity registers.
- `busy`: held from an accepted resize until the erase engine reports completion.
- `seq_err`: a one-cycle pulse for any broken sequence.

Back-pressure is simple. `cmd_ready` is high whenever `busy` is low. A command is taken on a rising clock edge only when `cmd_valid` and `cmd_ready` are both high. While `busy` is high, an offered command is not taken and has no effect. All outputs are registered and change on the edge that accepts the command.

Top module: `vcmd_seq_decoder`

## Requirements
- R1: After reset, `report_mode`, `busy`, `boot_upd`, `erase_req`, `seq_err` and `rd_report` are 0, `boot_size` is 0, and `cmd_ready` is 1.
- R2: In idle, index 62 with argument 0xEFAC62EC unlocks the decoder. If the next accepted command is index 62 with argument 0x0000CCEE, `report_mode` becomes 1 on that command's edge.
- R3: After an unlock, index 62 with argument 0x00DECCEE clears `report_mode` on that command's edge.
- R4: The resize sequence is: unlock, then index 62 with argument 0x00CBAEA7, then index 62 whose argument N lies in 1..128. On that third edge, `boot_upd` and `erase_req` pulse high for exactly one cycle and `boot_size` takes N[7:0]. `boot_size` then holds N until the next accepted resize.
- R5: A size argument of 0, or any value above 128, in the third step pulses `seq_err`. In that case `boot_upd`, `erase_req` and `busy` stay 0, and `boot_size` keeps its old value.
- R6: `busy` rises on the edge where `erase_req` pulses. It stays high until an edge on which `erase_done` is sampled high, and falls on that edge. While `busy` is high, `cmd_ready` is 0, and offered commands are not accepted and change no state.
- R7: In the middle of a sequence (after the unlock, or after the resize key), an accepted command of any other index, or an index-62 command with an unexpected argument, pulses `seq_err` for one cycle and returns the decoder to idle.
- R8: In idle, an index-62 command whose argument is not the unlock key pulses `seq_err` and changes no mode. A command of any other index in idle raises no error.
- R9: When index 17 with argument 0 is accepted while `report_mode` is 1, `rd_report` pulses for one cycle. No pulse is produced for index 17 with a nonzero address, or when `report_mode` is 0. The pulse occurs whatever the sequence state is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Decoded command offered |
| cmd_ready | output | 1 | Command can be taken (low while busy) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| erase_done | input | 1 | Erase engine finished |
| report_mode | output | 1 | Diagnostic report mode active |
| rd_report | output | 1 | Pulse: steer this read to the report sector |
| boot_upd | output | 1 | Pulse: new boot size applied |
| boot_size | output | 8 | Last applied boot size (super blocks / 2) |
| erase_req | output | 1 | Pulse: request full user-data erase |
| busy | output | 1 | Erase in progress after a resize |
| seq_err | output | 1 | Pulse: sequence aborted or rejected |

## Verification
Two functions can fall on the same edge: an abort of a half-finished sequence and the report-sector steering of a read. The bench provokes this by switching report mode on, sending the unlock key, and then sending a read of address 0. On that single edge the bench expects both `seq_err` and `rd_report` high, with `report_mode` left at 1. A behavioural model run alongside the design must agree with it on every output in every cycle, including the cycles where offered commands are refused during busy.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;
  localparam int unsigned VCMD_INDEX      = 62;
  localparam int unsigned RD_SINGLE_INDEX = 17;

  localparam logic [31:0] KEY_UNLOCK  = 32'hEFAC_62EC;
  localparam logic [31:0] KEY_RPT_ON  = 32'h0000_CCEE;
  localparam logic [31:0] KEY_RPT_OFF = 32'h00DE_CCEE;
  localparam logic [31:0] KEY_BOOT    = 32'h00CB_AEA7;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_OPEN = 2'd1,
    SEQ_BOOT = 2'd2
  } seq_state_t;

  typedef enum logic [2:0] {
    ARG_OTHER   = 3'd0,
    ARG_UNLOCK  = 3'd1,
    ARG_RPT_ON  = 3'd2,
    ARG_RPT_OFF = 3'd3,
    ARG_BOOT    = 3'd4
  } arg_class_t;

  typedef struct packed {
    logic       is_vcmd;
    logic       is_rd0;
    arg_class_t cls;
    logic       size_ok;
  } cmd_info_t;
endpackage

// File: rtl/vcmd_classify.sv
module vcmd_classify
  import vcmd_pkg::*;
#(
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned ARG_W    = 32,
  parameter int unsigned SIZE_W   = 8,
  parameter int unsigned MAX_SIZE = 128
) (
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [ARG_W-1:0]  cmd_arg,
  output cmd_info_t         info,
  output logic [SIZE_W-1:0] size_val
);
  localparam logic [ARG_W-1:0] MAX_ARG = ARG_W'(MAX_SIZE);

  always_comb begin
    info.is_vcmd = (cmd_index == IDX_W'(VCMD_INDEX));
    info.is_rd0  = (cmd_index == IDX_W'(RD_SINGLE_INDEX)) && (cmd_arg == '0);
    if (cmd_arg == ARG_W'(KEY_UNLOCK))       info.cls = ARG_UNLOCK;
    else if (cmd_arg == ARG_W'(KEY_RPT_ON))  info.cls = ARG_RPT_ON;
    else if (cmd_arg == ARG_W'(KEY_RPT_OFF)) info.cls = ARG_RPT_OFF;
    else if (cmd_arg == ARG_W'(KEY_BOOT))    info.cls = ARG_BOOT;
    else                                     info.cls = ARG_OTHER;
    info.size_ok = (cmd_arg != '0) && (cmd_arg <= MAX_ARG);
    size_val     = cmd_arg[SIZE_W-1:0];
  end
endmodule

// File: rtl/vcmd_seq_fsm.sv
module vcmd_seq_fsm
  import vcmd_pkg::*;
#(
  parameter int unsigned SIZE_W   = 8,
  parameter int unsigned MAX_SIZE = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  cmd_info_t         info,
  input  logic [SIZE_W-1:0] size_val,
  output logic              launch,
  output logic              report_mode,
  output logic              rd_report,
  output logic              boot_upd,
  output logic [SIZE_W-1:0] boot_size,
  output logic              erase_req,
  output logic              seq_err
);
  seq_state_t state;

  assign launch = accept && (state == SEQ_BOOT) && info.is_vcmd && info.size_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SEQ_IDLE;
      report_mode <= 1'b0;
      rd_report   <= 1'b0;
      boot_upd    <= 1'b0;
      boot_size   <= '0;
      erase_req   <= 1'b0;
      seq_err     <= 1'b0;
    end else begin
      boot_upd  <= 1'b0;
      erase_req <= 1'b0;
      seq_err   <= 1'b0;
      rd_report <= 1'b0;
      if (accept) begin
        rd_report <= info.is_rd0 && report_mode;
        case (state)
          SEQ_IDLE: begin
            if (info.is_vcmd) begin
              if (info.cls == ARG_UNLOCK) state <= SEQ_OPEN;
              else                        seq_err <= 1'b1;
            end
          end
          SEQ_OPEN: begin
            state <= SEQ_IDLE;
            if (info.is_vcmd && info.cls == ARG_RPT_ON)       report_mode <= 1'b1;
            else if (info.is_vcmd && info.cls == ARG_RPT_OFF) report_mode <= 1'b0;
            else if (info.is_vcmd && info.cls == ARG_BOOT)    state <= SEQ_BOOT;
            else                                               seq_err <= 1'b1;
          end
          SEQ_BOOT: begin
            state <= SEQ_IDLE;
            if (info.is_vcmd && info.size_ok) begin
              boot_upd  <= 1'b1;
              erase_req <= 1'b1;
              boot_size <= size_val;
            end else begin
              seq_err <= 1'b1;
            end
          end
          default: state <= SEQ_IDLE;
        endcase
      end
    end
  end

  // R2 R3
  mode_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(report_mode) |-> $past(accept && info.is_vcmd));

  // R4
  size_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_upd |-> (boot_size != '0) && (boot_size <= SIZE_W'(MAX_SIZE)));

  // R5
  err_excl_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_err && boot_upd));

  // R4
  upd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_upd |=> !boot_upd);
endmodule

// File: rtl/vcmd_busy.sv
module vcmd_busy (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic erase_done,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy <= 1'b0;
    else if (start)      busy <= 1'b1;
    else if (erase_done) busy <= 1'b0;
  end

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !erase_done |=> busy);

  // R6
  busy_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/vcmd_seq_decoder.sv
module vcmd_seq_decoder
  import vcmd_pkg::*;
#(
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned ARG_W    = 32,
  parameter int unsigned SIZE_W   = 8,
  parameter int unsigned MAX_SIZE = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic              erase_done,
  output logic              report_mode,
  output logic              rd_report,
  output logic              boot_upd,
  output logic [SIZE_W-1:0] boot_size,
  output logic              erase_req,
  output logic              busy,
  output logic              seq_err
);
  cmd_info_t         info;
  logic [SIZE_W-1:0] size_val;
  logic              launch;
  logic              accept;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  vcmd_classify #(
    .IDX_W(IDX_W), .ARG_W(ARG_W), .SIZE_W(SIZE_W), .MAX_SIZE(MAX_SIZE)
  ) u_cls (
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .info(info), .size_val(size_val)
  );

  vcmd_seq_fsm #(.SIZE_W(SIZE_W), .MAX_SIZE(MAX_SIZE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .info(info), .size_val(size_val),
    .launch(launch), .report_mode(report_mode), .rd_report(rd_report),
    .boot_upd(boot_upd), .boot_size(boot_size), .erase_req(erase_req),
    .seq_err(seq_err)
  );

  vcmd_busy u_busy (
    .clk(clk), .rst_n(rst_n), .start(launch), .erase_done(erase_done), .busy(busy)
  );

  // R6
  erase_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> busy);

  // R6
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && busy |-> $stable(report_mode) && !boot_upd && !seq_err);
endmodule

// File: tb/vcmd_seq_decoder_test.sv
module vcmd_seq_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic        erase_done = 1'b0;
  logic        report_mode, rd_report, boot_upd, erase_req, busy, seq_err;
  logic [7:0]  boot_size;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcmd_seq_decoder uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .erase_done(erase_done),
    .report_mode(report_mode), .rd_report(rd_report), .boot_upd(boot_upd),
    .boot_size(boot_size), .erase_req(erase_req), .busy(busy), .seq_err(seq_err)
  );

  // behavioural reference
  int   m_step;   // 0 idle, 1 unlocked, 2 resize armed
  bit   m_mode, m_rd, m_upd, m_erase, m_busy, m_err;
  int   m_size;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_mode = 0; m_rd = 0; m_upd = 0; m_erase = 0;
      m_busy = 0; m_err = 0; m_size = 0;
    end else begin
      bit acc;
      acc = cmd_valid && !m_busy;
      m_rd = 0; m_upd = 0; m_erase = 0; m_err = 0;
      if (m_busy && erase_done) m_busy = 0;
      if (acc) begin
        m_rd = (cmd_index == 17) && (cmd_arg == 0) && m_mode;
        if (m_step == 0) begin
          if (cmd_index == 62) begin
            if (cmd_arg == 32'hEFAC62EC) m_step = 1; else m_err = 1;
          end
        end else if (m_step == 1) begin
          m_step = 0;
          if (cmd_index == 62 && cmd_arg == 32'h0000CCEE) m_mode = 1;
          else if (cmd_index == 62 && cmd_arg == 32'h00DECCEE) m_mode = 0;
          else if (cmd_index == 62 && cmd_arg == 32'h00CBAEA7) m_step = 2;
          else m_err = 1;
        end else begin
          m_step = 0;
          if (cmd_index == 62 && cmd_arg >= 1 && cmd_arg <= 128) begin
            m_upd = 1; m_erase = 1; m_busy = 1; m_size = int'(cmd_arg);
          end else m_err = 1;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "report_mode", int'(report_mode), int'(m_mode));
      chk(cur_req, "rd_report",   int'(rd_report),   int'(m_rd));
      chk(cur_req, "boot_upd",    int'(boot_upd),    int'(m_upd));
      chk(cur_req, "erase_req",   int'(erase_req),   int'(m_erase));
      chk(cur_req, "busy",        int'(busy),        int'(m_busy));
      chk(cur_req, "cmd_ready",   int'(cmd_ready),   int'(!m_busy));
      chk(cur_req, "seq_err",     int'(seq_err),     int'(m_err));
      chk(cur_req, "boot_size",   int'(boot_size),   m_size);
    end
  end

  task automatic send(input int idx, input logic [31:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = 6'(idx); cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_erase();
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
  endtask

  task automatic resize(input logic [31:0] n);
    send(62, 32'hEFAC62EC);
    send(62, 32'h00CBAEA7);
    send(62, n);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "boot_size in reset", int'(boot_size), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", int'(cmd_ready), 1);
    chk("R1", "mode after reset", int'(report_mode), 0);

    cur_req = "R8";
    send(24, 32'h0000_0100);
    chk("R8", "other index idle no error", int'(seq_err), 0);
    send(62, 32'h0000CCEE);
    chk("R8", "key without unlock errors", int'(seq_err), 1);
    chk("R8", "mode unchanged", int'(report_mode), 0);

    cur_req = "R2";
    send(62, 32'hEFAC62EC);
    send(62, 32'h0000CCEE);
    chk("R2", "report mode on", int'(report_mode), 1);

    cur_req = "R9";
    send(17, 32'h0);
    chk("R9", "read addr0 steered", int'(rd_report), 1);
    send(17, 32'h8);
    chk("R9", "read addr8 not steered", int'(rd_report), 0);
    send(62, 32'hEFAC62EC);
    send(17, 32'h0);
    chk("R9", "steer during abort", int'(rd_report), 1);
    chk("R7", "abort same edge", int'(seq_err), 1);
    chk("R7", "mode kept on abort", int'(report_mode), 1);

    cur_req = "R3";
    send(62, 32'hEFAC62EC);
    send(62, 32'h00DECCEE);
    chk("R3", "report mode off", int'(report_mode), 0);
    send(17, 32'h0);
    chk("R9", "no steer when off", int'(rd_report), 0);

    cur_req = "R4";
    resize(32'd5);
    chk("R4", "upd strobe", int'(boot_upd), 1);
    chk("R4", "erase req", int'(erase_req), 1);
    chk("R4", "size value", int'(boot_size), 5);
    chk("R6", "busy raised", int'(busy), 1);
    cur_req = "R6";
    @(negedge clk);
    chk("R4", "upd one cycle", int'(boot_upd), 0);
    send(62, 32'hEFAC62EC);
    chk("R6", "still busy", int'(busy), 1);
    chk("R6", "ready low", int'(cmd_ready), 0);
    finish_erase();
    chk("R6", "busy cleared", int'(busy), 0);
    send(62, 32'h0000CCEE);
    chk("R6", "unlock while busy ignored", int'(report_mode), 0);
    chk("R8", "stray key errors", int'(seq_err), 1);

    cur_req = "R4";
    resize(32'd128);
    chk("R4", "max size accepted", int'(boot_size), 128);
    finish_erase();
    resize(32'd1);
    chk("R4", "min size accepted", int'(boot_size), 1);
    finish_erase();

    cur_req = "R5";
    resize(32'd0);
    chk("R5", "zero rejected", int'(seq_err), 1);
    chk("R5", "no erase on zero", int'(erase_req), 0);
    resize(32'd129);
    chk("R5", "129 rejected", int'(seq_err), 1);
    chk("R5", "size kept", int'(boot_size), 1);
    resize(32'h0001_0005);
    chk("R5", "wide arg rejected", int'(seq_err), 1);
    chk("R5", "not busy", int'(busy), 0);

    cur_req = "R7";
    send(62, 32'hEFAC62EC);
    send(13, 32'h0);
    chk("R7", "other index after unlock", int'(seq_err), 1);
    send(62, 32'h0000CCEE);
    chk("R7", "back to idle", int'(report_mode), 0);
    send(62, 32'hEFAC62EC);
    send(62, 32'h00CBAEA7);
    send(24, 32'h5);
    chk("R7", "other index after resize key", int'(seq_err), 1);
    chk("R7", "no erase", int'(erase_req), 0);
    send(62, 32'hEFAC62EC);
    send(62, 32'h1234_5678);
    chk("R7", "bad argument after unlock", int'(seq_err), 1);

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule